// File: doc/BRIEF.md
# TDM Transmit Subchannel Multiplexer

This block drives one serial transmit line of a time-division multiplexed link. A programmable table describes the frame. Each table entry names a source channel and carries an 8-bit mask that selects which bit positions of an 8-bit slot the channel fills. Several entries can share one slot, so each channel can take only part of a byte. For every bit strobe, the block works out which channel owns the current bit position and sends that channel's next data bit. It sends a high level when no channel owns the bit.

Every channel has one holding byte inside the block. An external source loads that byte through a fill port. When a channel has shifted out all eight bits of its byte, the block pulses a request that carries the channel number and the channel's parameter-area address. A slot with no valid entry releases the line: the output enable drops, so other devices can drive a shared open-drain wire. A frame ends at the entry flagged as wrap. The line then stays released until the next frame sync.

Top module: `tdm_tx_submux`

## Requirements
- R1: After reset, tx_data is 1, tx_oe is 0 and req_valid is 0. Until the first bit strobe that has fsync high, every bit strobe leaves tx_data at 1 and tx_oe at 0.
- R2: A table entry is written as bit 15 valid, bit 14 wrap, bit 13 last, bits 12:8 channel pointer, bits 7:0 mask. If no member entry of a slot group has valid set, all 8 bits of that slot give tx_data 1 and tx_oe 0.
- R3: In a slot group with at least one valid member, a bit position that no valid member claims gives tx_data 1 with tx_oe 1. Slot bit k, counting the first bit sent as 0, is claimed by mask bit k.
- R4: A bit position claimed by a valid member sends the owning channel's next holding-byte bit, most significant bit first, with tx_oe 1. A channel's bit counter advances only when that channel sends a bit.
- R5: A slot group starts at the current entry and takes in the entries that follow it. It ends at the first entry with last or wrap set, or after MAX_SUB entries, whichever comes first. When several valid members claim the same position, the member nearest the group's start owns it. The entry after the group starts the next slot.
- R6: After the slot whose group contains a wrap entry, bit strobes give tx_data 1 and tx_oe 0 until a bit strobe with fsync high.
- R7: When a channel sends the eighth bit of its byte, req_valid is high for exactly one clock, together with that bit. req_chan gives the channel, and req_addr gives the channel pointer followed by six zero bits.
- R8: Outputs change only in the clock after a bit strobe. Between strobes they hold, and req_valid is 0.
- R9: A bit strobe with fsync high restarts the frame at entry 0, bit 0, even in the middle of a frame, and that strobe sends bit 0 of entry 0's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe per serial bit |
| fsync | input | 1 | Frame sync, sampled with bit_tick |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IDX_W | Table entry index |
| tbl_wdata | input | 16 | Table entry value |
| fill_we | input | 1 | Holding-byte load enable |
| fill_chan | input | 5 | Channel to load |
| fill_byte | input | 8 | Byte to load |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for the line |
| req_valid | output | 1 | Byte request pulse |
| req_chan | output | 5 | Requesting channel |
| req_addr | output | 11 | Parameter-area address of the requesting channel |

## Verification
The assertions assume that bit_tick is low during reset and that fsync is only meaningful while bit_tick is high. They also assume that the table does not change while a frame is running, and that a channel's holding byte is refilled before that channel sends its next bit. The stimulus follows these rules. It rewrites the table only after a wrap has released the line. It raises fsync only together with a strobe. After every request it refills the channel in a clock that has no strobe, before the next strobe is issued.

// File: rtl/tdm_tx_pkg.sv
// Shared types and widths for the TDM transmit subchannel multiplexer.
// Assumes 8-bit slots and a 5-bit channel pointer scaled by 64 bytes.
package tdm_tx_pkg;
    localparam int PTR_W     = 5;
    localparam int MASK_W    = 8;
    localparam int ADDR_LSB  = 6;
    localparam int CADDR_W   = PTR_W + ADDR_LSB;
    localparam int NUM_CH    = 1 << PTR_W;
    localparam int CNT_W     = $clog2(MASK_W);

    typedef struct packed {
        logic              valid;
        logic              wrap;
        logic              last;
        logic [PTR_W-1:0]  ptr;
        logic [MASK_W-1:0] mask;
    } tsa_entry_t;

    localparam int ENTRY_W = $bits(tsa_entry_t);
endpackage

// File: rtl/tdm_tsa_table.sv
// Slot assignment table: register file with one write port. It presents
// MAX_SUB consecutive entries starting at 'base', wrapping modulo DEPTH.
// Assumes DEPTH is a power of two.
module tdm_tsa_table import tdm_tx_pkg::*; #(
    parameter int DEPTH   = 16,
    parameter int MAX_SUB = 4,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tsa_entry_t                wr_entry,
    input  logic [IDX_W-1:0]          base,
    output tsa_entry_t [MAX_SUB-1:0]  grp
);
    tsa_entry_t mem [DEPTH];

    // Clear all entries on reset, then accept single-entry writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    // Read window of candidate group members.
    for (genvar j = 0; j < MAX_SUB; j++) begin : g_win
        assign grp[j] = mem[base + IDX_W'(j)];
    end
endmodule

// File: rtl/tdm_slot_resolver.sv
// Combinational slot resolver. It finds the extent of the slot group, decides
// whether the slot is valid, picks the owner of one bit position (the first
// valid member whose mask bit is set), and reports whether the group holds
// the wrap entry.
module tdm_slot_resolver import tdm_tx_pkg::*; #(
    parameter int MAX_SUB = 4,
    parameter int LEN_W   = $clog2(MAX_SUB + 1)
) (
    input  tsa_entry_t [MAX_SUB-1:0] grp,
    input  logic [CNT_W-1:0]         bitpos,
    output logic                     any_valid,
    output logic                     has_owner,
    output logic [PTR_W-1:0]         owner_ptr,
    output logic                     grp_wrap,
    output logic [LEN_W-1:0]         grp_len
);
    // Scan members in order until the group closes.
    always_comb begin
        logic open;
        open      = 1'b1;
        any_valid = 1'b0;
        has_owner = 1'b0;
        owner_ptr = '0;
        grp_wrap  = 1'b0;
        grp_len   = '0;
        for (int j = 0; j < MAX_SUB; j++) begin
            if (open) begin
                grp_len = LEN_W'(j + 1);
                if (grp[j].valid) begin
                    any_valid = 1'b1;
                    if (!has_owner && grp[j].mask[bitpos]) begin
                        has_owner = 1'b1;
                        owner_ptr = grp[j].ptr;
                    end
                end
                if (grp[j].wrap) grp_wrap = 1'b1;
                if (grp[j].last || grp[j].wrap) open = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_chan_store.sv
// Per-channel holding byte and bit counter. It gives the next bit of the
// selected channel (MSB first) and flags the byte's final bit. The counter
// advances only on 'consume'. A fill does not touch the counter.
module tdm_chan_store import tdm_tx_pkg::*; #(
    parameter int CHANNELS = NUM_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_we,
    input  logic [PTR_W-1:0]   fill_chan,
    input  logic [MASK_W-1:0]  fill_byte,
    input  logic [PTR_W-1:0]   rd_chan,
    input  logic               consume,
    output logic               cur_bit,
    output logic               byte_done
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MASK_W - 1);

    logic [MASK_W-1:0] hold [CHANNELS];
    logic [CNT_W-1:0]  cnt  [CHANNELS];
    logic [MASK_W-1:0] sel_byte;
    logic [CNT_W-1:0]  sel_cnt;

    // Load holding bytes and advance the counter of the sending channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CHANNELS; i++) begin
                hold[i] <= '1;
                cnt[i]  <= '0;
            end
        end else begin
            if (fill_we) hold[fill_chan] <= fill_byte;
            if (consume) cnt[rd_chan] <= cnt[rd_chan] + 1'b1;
        end
    end

    // Select the current bit of the addressed channel.
    always_comb begin
        sel_byte  = hold[rd_chan];
        sel_cnt   = cnt[rd_chan];
        cur_bit   = sel_byte[TOP - sel_cnt];
        byte_done = (sel_cnt == TOP);
    end
endmodule

// File: rtl/tdm_tx_submux.sv
// TDM transmit subchannel multiplexer top. A bit sequencer walks the slot
// table one bit per bit_tick. It restarts at entry 0 on fsync and releases
// the line after the wrap slot until the next fsync. Outputs are registered
// and change in the clock after each strobe.
module tdm_tx_submux import tdm_tx_pkg::*; #(
    parameter int  DEPTH   = 16,
    parameter int  MAX_SUB = 4,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int LEN_W   = $clog2(MAX_SUB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               fsync,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [ENTRY_W-1:0] tbl_wdata,
    input  logic               fill_we,
    input  logic [PTR_W-1:0]   fill_chan,
    input  logic [MASK_W-1:0]  fill_byte,
    output logic               tx_data,
    output logic               tx_oe,
    output logic               req_valid,
    output logic [PTR_W-1:0]   req_chan,
    output logic [CADDR_W-1:0] req_addr
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(MASK_W - 1);

    logic                      running;
    logic [IDX_W-1:0]          base;
    logic [CNT_W-1:0]          bitpos;
    logic [IDX_W-1:0]          eff_base;
    logic [CNT_W-1:0]          eff_pos;
    logic                      eff_run;
    tsa_entry_t [MAX_SUB-1:0]  grp;
    logic                      any_valid;
    logic                      has_owner;
    logic [PTR_W-1:0]          owner_ptr;
    logic                      grp_wrap;
    logic [LEN_W-1:0]          grp_len;
    logic                      send_data;
    logic                      consume;
    logic                      cur_bit;
    logic                      byte_done;

    // Frame sync overrides the stored position for the current strobe.
    always_comb begin
        eff_base  = fsync ? '0 : base;
        eff_pos   = fsync ? '0 : bitpos;
        eff_run   = fsync | running;
        send_data = eff_run & any_valid & has_owner;
        consume   = bit_tick & send_data;
    end

    tdm_tsa_table #(.DEPTH(DEPTH), .MAX_SUB(MAX_SUB), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_addr),
        .wr_entry (tsa_entry_t'(tbl_wdata)),
        .base     (eff_base),
        .grp      (grp)
    );

    tdm_slot_resolver #(.MAX_SUB(MAX_SUB), .LEN_W(LEN_W)) u_resolve (
        .grp       (grp),
        .bitpos    (eff_pos),
        .any_valid (any_valid),
        .has_owner (has_owner),
        .owner_ptr (owner_ptr),
        .grp_wrap  (grp_wrap),
        .grp_len   (grp_len)
    );

    tdm_chan_store #(.CHANNELS(NUM_CH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_we),
        .fill_chan (fill_chan),
        .fill_byte (fill_byte),
        .rd_chan   (owner_ptr),
        .consume   (consume),
        .cur_bit   (cur_bit),
        .byte_done (byte_done)
    );

    // Sequencer: advance bit, slot and frame position on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            base    <= '0;
            bitpos  <= '0;
        end else if (bit_tick && eff_run) begin
            if (eff_pos == LAST_POS) begin
                bitpos  <= '0;
                running <= !grp_wrap;
                base    <= grp_wrap ? '0 : eff_base + IDX_W'(grp_len);
            end else begin
                bitpos  <= eff_pos + 1'b1;
                base    <= eff_base;
                running <= 1'b1;
            end
        end
    end

    // Output stage: register the line bit, drive enable and byte request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data   <= 1'b1;
            tx_oe     <= 1'b0;
            req_valid <= 1'b0;
            req_chan  <= '0;
            req_addr  <= '0;
        end else if (bit_tick) begin
            tx_oe     <= eff_run & any_valid;
            tx_data   <= send_data ? cur_bit : 1'b1;
            req_valid <= consume & byte_done;
            req_chan  <= owner_ptr;
            req_addr  <= {owner_ptr, {ADDR_LSB{1'b0}}};
        end else begin
            req_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_tx_submux_chk.sv
// Property checker for tdm_tx_submux, bound to every instance of the top.
// Assumes bit_tick is low during reset.
module tdm_tx_submux_chk import tdm_tx_pkg::*; (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_tick,
    input logic               fsync,
    input logic               tx_data,
    input logic               tx_oe,
    input logic               req_valid,
    input logic [PTR_W-1:0]   req_chan,
    input logic [CADDR_W-1:0] req_addr
);
    logic seen_sync;

    // Remember whether any frame sync has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_sync <= 1'b0;
        else if (bit_tick && fsync) seen_sync <= 1'b1;
    end

    AST_IDLE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync |-> (tx_data && !tx_oe && !req_valid)); // R1
    AST_RELEASED_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_data); // R2
    AST_REQ_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (tx_oe && $past(bit_tick))); // R7
    AST_REQ_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr == {req_chan, {ADDR_LSB{1'b0}}})); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> ($stable(tx_data) && $stable(tx_oe) && !req_valid)); // R8
endmodule

bind tdm_tx_submux tdm_tx_submux_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .fsync     (fsync),
    .tx_data   (tx_data),
    .tx_oe     (tx_oe),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .req_addr  (req_addr)
);

// File: tb/sim_tdm_tx_submux.sv
module sim_tdm_tx_submux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, fsync = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [15:0] tbl_wdata = '0;
    logic        fill_we = 1'b0;
    logic [4:0]  fill_chan = '0;
    logic [7:0]  fill_byte = '0;
    logic        tx_data, tx_oe, req_valid;
    logic [4:0]  req_chan;
    logic [10:0] req_addr;

    tdm_tx_submux u0 (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    logic [15:0] tbl [16];
    int mcnt [32];
    int mn [32];
    bit run = 0, started = 0;
    int mbase = 0, mpos = 0;
    string note = "";

    // scoreboard: {data, oe, req, chan[4:0]}
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] last_exp;
    bit         have_last = 0;
    bit         pending = 0;

    function automatic logic [7:0] byte_of(int c, int n);
        return 8'((c * 37 + n * 91 + 5) & 255);
    endfunction

    function automatic logic [15:0] ent(bit v, bit w, bit l, int p, logic [7:0] m);
        return {v, w, l, 5'(p), m};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compare one expectation per strobe, check hold otherwise
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pending) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected strobe result", 0, 1);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({tx_data, tx_oe} == e[7:6], t, "data/oe", {tx_data, tx_oe}, e[7:6]);
                    chk(req_valid == e[5], "R7", "req_valid", req_valid, e[5]);
                    if (e[5]) begin
                        chk(req_chan == e[4:0], "R7", "req_chan", req_chan, e[4:0]);
                        chk(req_addr == {e[4:0], 6'b0}, "R7", "req_addr", req_addr, {e[4:0], 6'b0});
                    end
                    last_exp = e;
                    have_last = 1;
                end
            end else if (have_last) begin
                chk({tx_data, tx_oe, req_valid} == {last_exp[7:6], 1'b0}, "R8", "hold between strobes",
                    {tx_data, tx_oe, req_valid}, {last_exp[7:6], 1'b0});
            end
            pending = bit_tick;
        end
    end

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic fill(int c, logic [7:0] b);
        fill_we = 1; fill_chan = 5'(c); fill_byte = b;
        @(posedge clk); #2;
        fill_we = 0;
    endtask

    task automatic wr(int idx, logic [15:0] v);
        tbl[idx] = v;
        tbl_we = 1; tbl_addr = 4'(idx); tbl_wdata = v;
        @(posedge clk); #2;
        tbl_we = 0;
    endtask

    // driver: model one strobe, push expectation, drive it
    task automatic tick(bit fs);
        bit d, o, r, anyv, wrp;
        int own, len, ch;
        string tg;
        logic [15:0] e;
        d = 1; o = 0; r = 0; ch = 0;
        if (fs) begin run = 1; started = 1; mbase = 0; mpos = 0; end
        if (!run) begin
            tg = started ? "R6" : "R1";
        end else begin
            own = -1; len = 0; wrp = 0; anyv = 0;
            for (int j = 0; j < 4; j++) begin
                e = tbl[(mbase + j) % 16];
                len = j + 1;
                if (e[15]) begin
                    anyv = 1;
                    if (own < 0 && e[mpos]) own = int'(e[12:8]);
                end
                if (e[14]) wrp = 1;
                if (e[13] || e[14]) break;
            end
            if (!anyv) begin
                tg = "R2";
            end else if (own < 0) begin
                o = 1; tg = "R3";
            end else begin
                logic [7:0] b;
                b = byte_of(own, mn[own]);
                o = 1; d = b[7 - mcnt[own]];
                tg = (len > 1) ? "R5" : "R4";
                ch = own;
                mcnt[own]++;
                if (mcnt[own] == 8) begin mcnt[own] = 0; mn[own]++; r = 1; end
            end
            mpos++;
            if (mpos == 8) begin
                mpos = 0;
                if (wrp) run = 0;
                else mbase = (mbase + len) % 16;
            end
        end
        if (note != "") begin tg = note; note = ""; end
        exp_q.push_back({d, o, r, 5'(ch)});
        tag_q.push_back(tg);
        bit_tick = 1; fsync = fs;
        @(posedge clk); #2;
        bit_tick = 0; fsync = 0;
        if (r) fill(ch, byte_of(ch, mn[ch]));
    endtask

    task automatic frame(int bits, int after, int gap);
        tick(1);
        for (int i = 1; i < bits; i++) begin
            tick(0);
            if (i % gap == 0) idle(2);
        end
        for (int i = 0; i < after; i++) tick(0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tbl[i] = '0;
        for (int i = 0; i < 32; i++) begin mcnt[i] = 0; mn[i] = 0; end
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset values
        @(negedge clk);
        chk(tx_data == 1 && tx_oe == 0 && req_valid == 0, "R1", "reset outputs",
            {tx_data, tx_oe, req_valid}, 3'b100);
        @(posedge clk); #2;
        for (int c = 0; c < 32; c++) fill(c, byte_of(c, 0));
        tick(0); tick(0); tick(0);               // R1: no frame before sync
        // table A: full slot, invalid slot, partial mask, split slot, overlap + wrap
        wr(0, ent(1, 0, 1, 3, 8'hFF));
        wr(1, ent(0, 0, 1, 4, 8'hFF));
        wr(2, ent(1, 0, 1, 5, 8'hA5));
        wr(3, ent(1, 0, 0, 7, 8'h0F));
        wr(4, ent(1, 0, 1, 9, 8'hF0));
        wr(5, ent(1, 0, 0, 7, 8'h3C));
        wr(6, ent(0, 0, 0, 2, 8'hFF));
        wr(7, ent(1, 1, 0, 11, 8'h0F));
        frame(48, 3, 5);
        frame(48, 1, 7);
        frame(48, 4, 100);
        frame(48, 0, 3);
        frame(48, 2, 11);
        // R9: sync arriving mid-frame
        tick(1);
        for (int i = 0; i < 19; i++) tick(0);
        note = "R9";
        tick(1);
        for (int i = 0; i < 47; i++) tick(0);
        tick(0); tick(0);
        // table B: group capped at MAX_SUB members, then wrap slot
        wr(0, ent(1, 0, 0, 1, 8'h01));
        wr(1, ent(0, 0, 0, 2, 8'h02));
        wr(2, ent(1, 0, 0, 3, 8'h04));
        wr(3, ent(1, 0, 0, 4, 8'h08));
        wr(4, ent(1, 1, 1, 5, 8'hFF));
        wr(5, '0); wr(6, '0); wr(7, '0);
        frame(16, 2, 6);
        frame(16, 0, 100);
        frame(16, 3, 4);
        idle(4);
        finished = 1;
        chk(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule